// File: doc/BRIEF.md
# I2C Register-File Target

This block is a target (slave) on a two-wire I2C bus. It owns a small bank of 8-bit registers and answers to one fixed 7-bit device address. A host that wants to store values sends the address with the write direction, then one byte that selects a register, then any number of data bytes. Each data byte lands in the selected register, and the selection then moves on to the next register. A host that wants to fetch values sends the address with the read direction and receives bytes starting at the current selection. The usual way to read a chosen register is a write that carries only the selection byte, followed by a repeated START and a read. The selection is kept across the repeated START, so the read begins at the chosen register.

Both bus lines are sampled through a two-flop synchroniser and a filter that needs two equal samples, and the block works on the filtered copies. SDA is only ever pulled low through an enable, and SCL can be held low through a second enable. A `data_ready` input lets surrounding logic delay the bus: while it is low at a byte boundary, the target keeps SCL low. It presents the next bit before it lets SCL go.

Top module: `i2c_regtarget`

## Requirements
- R1: A falling SDA while SCL is high is taken as START and resets address reception. A rising SDA while SCL is high is taken as STOP and returns the target to idle.
- R2: After START the first byte is the 7-bit address, sent MSB first, followed by a direction bit (1 = read, 0 = write). When the address equals `DEV_ADDR`, the target pulls SDA low for the whole ninth clock (ACK).
- R3: When the address does not match, the target sends no ACK and ignores all bytes until the next START. Registers keep their contents.
- R4: In a write, the first byte after the address selects the register (taken modulo `NREG`, which is a power of two), and each later byte is stored in the selected register. The target ACKs every byte it receives.
- R5: A read returns the selected register MSB first, one bit per SCL low phase. The selection survives a repeated START and a STOP.
- R6: The selection advances by one after every stored byte and after every byte loaded for a read, and it wraps from `NREG-1` to 0.
- R7: When the host answers a read byte with NACK (SDA high in the ninth clock), the target releases SDA and sends nothing more until the next START.
- R8: When `data_ready` is low at the end of an ACK clock (the next byte of a read or write), the target holds SCL low until `data_ready` is high. For a read, the first bit is on SDA before SCL is released.
- R9: After reset both enables are off, all registers read 0 and the selection is 0.
- R10: An SDA pulse that lasts one system-clock cycle is filtered out and is not seen as START, STOP or data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level as seen on the bus |
| sda_i | input | 1 | SDA line level as seen on the bus |
| data_ready | input | 1 | High when the target may continue; low requests clock stretching |
| sda_pull | output | 1 | Drive SDA low when 1 (open-drain enable) |
| scl_hold | output | 1 | Drive SCL low when 1 (stretch enable) |

## Verification
Two things meet in the same cycles when an SDA glitch lands inside the high phase of a data bit: that window is where START and STOP are detected, and it is also where the bit is sampled. The bench forces a one-cycle low pulse in the middle of the high phase of a 1 bit. It then expects the byte to be ACKed and the register to read back unchanged. In the second case the release of a stretched SCL coincides with loading the next read byte. The bench drops `data_ready` before a read, checks that the line stays low, and raises `data_ready` in the middle of the wait. The returned byte must then match the selected register.

// File: rtl/i2c_regtarget.sv
module i2c_regtarget #(
  parameter logic [6:0] DEV_ADDR = 7'h42,
  parameter int         NREG     = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic data_ready,
  output logic sda_pull,
  output logic scl_hold
);
  localparam int PW = (NREG > 1) ? $clog2(NREG) : 1;

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_WR, ST_RD} st_t;

  logic [2:0] scl_sy, sda_sy;
  logic scl_f, sda_f, scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= '1; sda_sy <= '1;
      scl_f  <= 1'b1; sda_f <= 1'b1;
      scl_d  <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[1:0], scl_i};
      sda_sy <= {sda_sy[1:0], sda_i};
      if (scl_sy[2] == scl_sy[1]) scl_f <= scl_sy[1];
      if (sda_sy[2] == sda_sy[1]) sda_f <= sda_sy[1];
      scl_d <= scl_f;
      sda_d <= sda_f;
    end

  wire scl_rise = scl_f & ~scl_d;
  wire scl_fall = ~scl_f & scl_d;
  wire start_c  = scl_f & scl_d & sda_d & ~sda_f;
  wire stop_c   = scl_f & scl_d & ~sda_d & sda_f;

  st_t        st;
  logic [3:0] cnt;
  logic [7:0] sh, tx;
  logic       rw, first, nack, pend, act_d;
  logic [PW-1:0] ptr;
  logic [7:0] regs [NREG];

  wire match     = (sh[7:1] == DEV_ADDR);
  wire ack_edge  = scl_fall && (cnt == 4'd8);
  wire wr_commit = ack_edge && (st == ST_WR) && !first;

  assign scl_hold = pend | act_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; sh <= '0; tx <= '0;
      rw <= 1'b0; first <= 1'b0; nack <= 1'b0;
      pend <= 1'b0; act_d <= 1'b0; ptr <= '0; sda_pull <= 1'b0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      act_d <= 1'b0;
      if (start_c) begin
        st <= ST_ADDR; cnt <= '0; sda_pull <= 1'b0; pend <= 1'b0;
      end else if (stop_c) begin
        st <= ST_IDLE; sda_pull <= 1'b0; pend <= 1'b0;
      end else if (pend) begin
        if (data_ready) begin
          pend  <= 1'b0;
          act_d <= 1'b1;
          if (st == ST_RD) begin
            sda_pull <= ~regs[ptr][7];
            tx       <= {regs[ptr][6:0], 1'b0};
            ptr      <= ptr + 1'b1;
          end
        end
      end else if (st != ST_IDLE) begin
        if (scl_rise) begin
          if (cnt < 4'd8) sh <= {sh[6:0], sda_f};
          else            nack <= sda_f;
          cnt <= cnt + 4'd1;
        end else if (ack_edge) begin
          case (st)
            ST_ADDR: if (match) begin sda_pull <= 1'b1; rw <= sh[0]; end
                     else st <= ST_IDLE;
            ST_WR: begin
              sda_pull <= 1'b1;
              if (first) begin ptr <= sh[PW-1:0]; first <= 1'b0; end
              else if (wr_commit) begin regs[ptr] <= sh; ptr <= ptr + 1'b1; end
            end
            default: sda_pull <= 1'b0;
          endcase
        end else if (scl_fall && cnt == 4'd9) begin
          cnt <= '0;
          sda_pull <= 1'b0;
          case (st)
            ST_ADDR: begin st <= rw ? ST_RD : ST_WR; first <= 1'b1; pend <= 1'b1; end
            ST_RD:   if (nack) st <= ST_IDLE; else pend <= 1'b1;
            default: pend <= 1'b1;
          endcase
        end else if (scl_fall && st == ST_RD && cnt != 4'd0) begin
          sda_pull <= ~tx[7];
          tx <= tx << 1;
        end
      end
    end
endmodule

// File: rtl/i2c_regtarget_chk.sv
module i2c_regtarget_chk #(
  parameter int PW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_c,
  input logic          stop_c,
  input logic [1:0]    st,
  input logic [3:0]    cnt,
  input logic          scl_f,
  input logic          sda_pull,
  input logic          scl_hold,
  input logic          pend,
  input logic          data_ready,
  input logic          wr_commit,
  input logic [PW-1:0] ptr
);
  AST_START_ENTERS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> (st == 2'd1 && cnt == 4'd0)); // R1
  AST_STOP_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> (st == 2'd0)); // R1
  AST_IDLE_NO_PULL: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0) |-> !sda_pull); // R3
  AST_SDA_STILL_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_f && $past(scl_f) && !$past(start_c) && !$past(stop_c)) |-> $stable(sda_pull)); // R2
  AST_STRETCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !data_ready && !start_c && !stop_c) |=> scl_hold); // R8
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> (ptr == $past(ptr) + 1'b1)); // R6
endmodule

bind i2c_regtarget i2c_regtarget_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_c(start_c), .stop_c(stop_c),
  .st(st), .cnt(cnt), .scl_f(scl_f), .sda_pull(sda_pull),
  .scl_hold(scl_hold), .pend(pend), .data_ready(data_ready),
  .wr_commit(wr_commit), .ptr(ptr)
);

// File: tb/sim_i2c_regtarget.sv
module sim_i2c_regtarget;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 10;
  localparam logic [6:0] ADDR = 7'h42;
  localparam logic [15:0] VEC [6] = '{16'h003C, 16'h07A5, 16'h03FF,
                                      16'h0500, 16'h0196, 16'h0A5E};

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, gl_n = 1'b1, ready = 1'b1;
  logic sda_pull, scl_hold, scl_bus, sda_bus;
  int checks = 0, fails = 0;

  assign scl_bus = m_scl & ~scl_hold;
  assign sda_bus = m_sda & ~sda_pull & gl_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_regtarget #(.DEV_ADDR(ADDR), .NREG(8)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .data_ready(ready), .sda_pull(sda_pull), .scl_hold(scl_hold));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_high;
    while (!scl_bus) @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; wait_high; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; wait_high; tick(Q);
    m_sda = 1'b1; tick(Q);
  endtask

  task automatic clk_bit(input bit b, input bit glitch, output bit s);
    m_sda = b; tick(Q);
    m_scl = 1'b1; wait_high; tick(Q/2);
    if (glitch) begin gl_n = 1'b0; tick(1); gl_n = 1'b1; end
    tick(Q/2);
    s = sda_bus;
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic wr_byte(input logic [7:0] d, input int gb, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) clk_bit(d[i], gb == i, s);
    clk_bit(1'b1, 1'b0, s);
    ack = !s;
  endtask

  task automatic rd_byte(input bit mack, output logic [7:0] d);
    bit s;
    d = '0;
    for (int i = 0; i < 8; i++) begin clk_bit(1'b1, 1'b0, s); d = {d[6:0], s}; end
    clk_bit(!mack, 1'b0, s);
  endtask

  task automatic w_one(input logic [6:0] a, input logic [7:0] p, input logic [7:0] d,
                       input int gb, output bit a0, output bit a1, output bit a2);
    bus_start;
    wr_byte({a, 1'b0}, -1, a0);
    wr_byte(p, -1, a1);
    wr_byte(d, gb, a2);
    bus_stop;
  endtask

  task automatic r_at(input logic [7:0] p, output logic [7:0] d, output bit a0);
    bit x;
    bus_start;
    wr_byte({ADDR, 1'b0}, -1, x);
    wr_byte(p, -1, x);
    bus_start;
    wr_byte({ADDR, 1'b1}, -1, a0);
    rd_byte(1'b0, d);
    bus_stop;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, -1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    bit a0, a1, a2, s;
    logic [7:0] d;
    tick(5); rst_n = 1'b1; tick(5);
    chk("R9 sda_pull after reset", int'(sda_pull), 0);
    chk("R9 scl_hold after reset", int'(scl_hold), 0);
    r_at(8'd4, d, a0);
    chk("R9 register reset value", d, 0);

    for (int v = 0; v < 6; v++) begin
      w_one(ADDR, VEC[v][15:8], VEC[v][7:0], -1, a0, a1, a2);
      chk("R1 R2 address ack", a0, 1);
      chk("R4 pointer byte ack", a1, 1);
      chk("R4 data byte ack", a2, 1);
      r_at(VEC[v][15:8], d, a0);
      chk("R5 readback", d, VEC[v][7:0]);
    end

    w_one(ADDR ^ 7'h01, 8'd3, 8'h11, -1, a0, a1, a2);
    chk("R3 no ack on foreign address", a0, 0);
    chk("R3 no ack on later byte", a2, 0);
    r_at(8'd3, d, a0);
    chk("R3 register untouched", d, 8'hFF);

    bus_start;
    wr_byte({ADDR, 1'b0}, -1, a0);
    wr_byte(8'd6, -1, a1);
    wr_byte(8'hD1, -1, a2);
    wr_byte(8'hD2, -1, a2);
    wr_byte(8'hD3, -1, a2);
    chk("R4 burst byte ack", a2, 1);
    bus_stop;
    bus_start;
    wr_byte({ADDR, 1'b0}, -1, a0);
    wr_byte(8'd6, -1, a1);
    bus_start;
    wr_byte({ADDR, 1'b1}, -1, a0);
    rd_byte(1'b1, d); chk("R6 burst read reg6", d, 8'hD1);
    rd_byte(1'b1, d); chk("R6 burst read reg7", d, 8'hD2);
    rd_byte(1'b0, d); chk("R6 wrap read reg0", d, 8'hD3);
    tick(Q);
    chk("R7 SDA released after NACK", int'(sda_pull), 0);
    clk_bit(1'b1, 1'b0, s);
    chk("R7 nothing sent after NACK", s, 1);
    bus_stop;

    bus_start;
    wr_byte({ADDR, 1'b1}, -1, a0);
    rd_byte(1'b0, d);
    bus_stop;
    chk("R5 R6 pointer kept across STOP", d, 8'h96);

    ready = 1'b0;
    bus_start;
    wr_byte({ADDR, 1'b1}, -1, a0);
    chk("R8 address ack before stretch", a0, 1);
    fork
      rd_byte(1'b0, d);
      begin
        tick(60);
        chk("R8 SCL held low", int'(scl_bus), 0);
        chk("R8 hold enable", int'(scl_hold), 1);
        ready = 1'b1;
      end
    join
    bus_stop;
    chk("R8 data after stretch", d, 8'h5E);

    w_one(ADDR, 8'd4, 8'hF0, 7, a0, a1, a2);
    chk("R10 ack despite glitch", a2, 1);
    r_at(8'd4, d, a0);
    chk("R10 value despite glitch", d, 8'hF0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule